// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves a single source operand for an instruction whose fields have already been decoded. Each request carries a 4-bit mode code, a base register selector, an index register selector, a displacement/literal field, a step value and the current program counter. The unit reads the register file through two combinational read ports. It issues word reads to data memory over a valid/ready request channel, and each read comes back on a response channel with a valid strobe. When the operand is ready, the unit presents it together with a one-cycle done pulse.

Some modes need more than one access. The pointer-to-pointer mode chains two memory reads. The post-increment and pre-decrement modes write a new base value back through a register-file write port, and the address each one uses follows its own order relative to that update. The register file and the memory sit outside the unit.

Top module: `operand_fetch_unit`

## Requirements
- R1: Mode 0 (register) returns the selected base register's contents and makes no memory request.
- R2: Mode 1 (literal) returns the displacement field unchanged and makes no memory request.
- R3: Single-read modes issue exactly one read and return its data. Mode 2 reads at the displacement. Mode 3 reads at the base register. Mode 4 reads at displacement plus base. Mode 5 reads at base plus index register. Mode 10 reads at program counter plus displacement.
- R4: Mode 9 (scaled) reads at displacement plus base plus index times step, all modulo 2^16.
- R5: Mode 6 (pointer to pointer) first reads at the base register value, then reads at the returned word, and returns the second word.
- R6: Mode 7 (post-increment) reads at the base value held before the update and writes base plus step into the base register once.
- R7: Mode 8 (pre-decrement) writes base minus step into the base register once and reads at that decremented value.
- R8: Mode codes 11 to 15 return zero, make no memory request, and raise the illegal flag only during the done cycle.
- R9: A request is taken only while busy is low. Busy is high from the cycle after acceptance through the done cycle. Request inputs that arrive while busy is high are ignored.
- R10: A memory request keeps its valid high and its address unchanged until ready is seen. The operand waits for the response, whatever the ready and response delays.
- R11: Done is high for exactly one cycle per accepted request, and the operand is valid in that cycle. After reset, busy, done, the memory request and the register write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New operand request |
| req_mode | input | 4 | Addressing mode code |
| req_base | input | RW | Base register selector |
| req_index | input | RW | Index register selector |
| req_disp | input | DW | Displacement, absolute address or literal |
| req_step | input | DW | Step/scale value d |
| req_pc | input | DW | Program counter value |
| busy | output | 1 | Unit is working on a request |
| rf_a_sel | output | RW | Register read port A selector (base) |
| rf_a_data | input | DW | Register read port A data |
| rf_b_sel | output | RW | Register read port B selector (index) |
| rf_b_data | input | DW | Register read port B data |
| rf_we | output | 1 | Base register write enable |
| rf_wsel | output | RW | Register write selector |
| rf_wdata | output | DW | Register write data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | DW | Memory word address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |
| done | output | 1 | Operand ready pulse |
| illegal | output | 1 | Illegal mode code flag |
| operand | output | DW | Resolved operand |

## Verification
The embedded assertions watch four things on every cycle. They check that a stalled memory request holds its valid and address. They check that done lasts a single cycle and only occurs while busy, that the illegal flag appears only with done, and that a base write never overlaps a memory request or the done cycle. They also check that busy rises only after a request. Address arithmetic, the order of the two chained reads, the base value before and after writeback, and the values returned can only be shown by the bench's scenarios. The bench's model predicts every memory address, every register write and every operand for each mode, under both immediate and stalled memory timing.

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_mode,
  input  logic [RW-1:0] req_base,
  input  logic [RW-1:0] req_index,
  input  logic [DW-1:0] req_disp,
  input  logic [DW-1:0] req_step,
  input  logic [DW-1:0] req_pc,
  output logic          busy,
  output logic [RW-1:0] rf_a_sel,
  input  logic [DW-1:0] rf_a_data,
  output logic [RW-1:0] rf_b_sel,
  input  logic [DW-1:0] rf_b_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wsel,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic          illegal,
  output logic [DW-1:0] operand
);

  localparam logic [3:0] M_REG    = 4'd0;
  localparam logic [3:0] M_LIT    = 4'd1;
  localparam logic [3:0] M_ABS    = 4'd2;
  localparam logic [3:0] M_PTR    = 4'd3;
  localparam logic [3:0] M_OFS    = 4'd4;
  localparam logic [3:0] M_IDX    = 4'd5;
  localparam logic [3:0] M_PTRPTR = 4'd6;
  localparam logic [3:0] M_POSTI  = 4'd7;
  localparam logic [3:0] M_PRED   = 4'd8;
  localparam logic [3:0] M_SCALE  = 4'd9;
  localparam logic [3:0] M_PCOFS  = 4'd10;

  typedef enum logic [2:0] {ST_IDLE, ST_EVAL, ST_REQ, ST_WAIT, ST_DONE} st_t;

  st_t           st;
  logic [3:0]    mode_q;
  logic [RW-1:0] base_q, idx_q;
  logic [DW-1:0] disp_q, step_q, pc_q, addr_q, res_q;
  logic          ill_q, second_q;
  logic [DW-1:0] ea, scaled;
  logic          bad_mode;

  assign rf_a_sel = base_q;
  assign rf_b_sel = idx_q;
  assign scaled   = rf_b_data * step_q;
  assign bad_mode = mode_q > M_PCOFS;

  always_comb begin
    case (mode_q)
      M_ABS:   ea = disp_q;
      M_OFS:   ea = disp_q + rf_a_data;
      M_IDX:   ea = rf_a_data + rf_b_data;
      M_PRED:  ea = rf_a_data - step_q;
      M_SCALE: ea = disp_q + rf_a_data + scaled;
      M_PCOFS: ea = pc_q + disp_q;
      default: ea = rf_a_data;
    endcase
  end

  assign busy          = st != ST_IDLE;
  assign done          = st == ST_DONE;
  assign illegal       = done && ill_q;
  assign operand       = res_q;
  assign mem_req_valid = st == ST_REQ;
  assign mem_req_addr  = addr_q;
  assign rf_we         = st == ST_EVAL && (mode_q == M_POSTI || mode_q == M_PRED);
  assign rf_wsel       = base_q;
  assign rf_wdata      = (mode_q == M_POSTI) ? rf_a_data + step_q : rf_a_data - step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode_q   <= '0;
      base_q   <= '0;
      idx_q    <= '0;
      disp_q   <= '0;
      step_q   <= '0;
      pc_q     <= '0;
      addr_q   <= '0;
      res_q    <= '0;
      ill_q    <= 1'b0;
      second_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          mode_q   <= req_mode;
          base_q   <= req_base;
          idx_q    <= req_index;
          disp_q   <= req_disp;
          step_q   <= req_step;
          pc_q     <= req_pc;
          ill_q    <= 1'b0;
          second_q <= 1'b0;
          st       <= ST_EVAL;
        end
        ST_EVAL: begin
          if (bad_mode) begin
            res_q <= '0;
            ill_q <= 1'b1;
            st    <= ST_DONE;
          end else if (mode_q == M_REG) begin
            res_q <= rf_a_data;
            st    <= ST_DONE;
          end else if (mode_q == M_LIT) begin
            res_q <= disp_q;
            st    <= ST_DONE;
          end else begin
            addr_q <= ea;
            st     <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (mode_q == M_PTRPTR && !second_q) begin
            addr_q   <= mem_rsp_data;
            second_q <= 1'b1;
            st       <= ST_REQ;
          end else begin
            res_q <= mem_rsp_data;
            st    <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R9
  done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9
  busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R6 R7
  wb_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy && !mem_req_valid && !done);

endmodule

// File: tb/operand_fetch_unit_tb.sv
module operand_fetch_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_mode = '0;
  logic [2:0]  req_base = '0, req_index = '0;
  logic [15:0] req_disp = '0, req_step = '0, req_pc = '0;
  logic        busy;
  logic [2:0]  rf_a_sel, rf_b_sel, rf_wsel;
  logic [15:0] rf_a_data, rf_b_data, rf_wdata;
  logic        rf_we;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        done, illegal;
  logic [15:0] operand;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_fetch_unit #(.DW(16), .RW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
    .req_step(req_step), .req_pc(req_pc), .busy(busy),
    .rf_a_sel(rf_a_sel), .rf_a_data(rf_a_data), .rf_b_sel(rf_b_sel),
    .rf_b_data(rf_b_data), .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .illegal(illegal), .operand(operand)
  );

  logic [15:0] rf [8];
  assign rf_a_data = rf[rf_a_sel];
  assign rf_b_data = rf[rf_b_sel];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 16'h1000 + 16'(i) * 16'h0111;
    end else if (rf_we) begin
      rf[rf_wsel] <= rf_wdata;
    end
  end

  function automatic logic [15:0] mf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  int checks = 0, errors = 0, cyc = 0;
  bit slow = 0;
  string cur_tag = "R11";
  logic [15:0] exp_addr [2];
  int exp_n = 0, seen_n = 0;
  bit exp_wb = 0;
  int wb_seen = 0;
  logic [15:0] exp_wdata = '0;
  logic [2:0]  exp_wsel = '0;
  logic [15:0] exp_op = '0;
  bit exp_ill = 0;
  bit inflight = 0, acc_pend = 0;
  bit pend = 0;
  int pend_wait = 0;
  logic [15:0] pend_addr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural model of memory timing and per-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(0, "R11", "watchdog expired", 16'(cyc), 16'(WATCHDOG));
        finish_run();
      end
      if (!rst_n) begin
        mem_rsp_valid = 0; mem_req_ready = 0; acc_pend = 0; inflight = 0; pend = 0;
      end else begin
        if (acc_pend) inflight = 1;
        acc_pend = 0;
        chk(busy == inflight, "R9", "busy", 16'(busy), 16'(inflight));
        mem_rsp_valid = 0;
        if (pend) begin
          if (pend_wait == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data = mf(pend_addr);
            pend = 0;
          end else pend_wait--;
        end
        mem_req_ready = slow ? (cyc % 3 == 2) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
          if (seen_n < exp_n)
            chk(mem_req_addr == exp_addr[seen_n], cur_tag, "memory address",
                mem_req_addr, exp_addr[seen_n]);
          else
            chk(0, cur_tag, "unexpected memory request", mem_req_addr, 16'h0);
          seen_n++;
          pend = 1;
          pend_addr = mem_req_addr;
          pend_wait = slow ? (cyc % 2) : 0;
        end
        if (rf_we) begin
          wb_seen++;
          chk(exp_wb && rf_wsel == exp_wsel && rf_wdata == exp_wdata, cur_tag,
              "base writeback", rf_wdata, exp_wdata);
        end
        if (!done) begin
          if (illegal) chk(0, "R8", "illegal without done", 16'(illegal), 16'h0);
        end else begin
          chk(operand == exp_op, cur_tag, "operand", operand, exp_op);
          chk(illegal == exp_ill, cur_tag, "illegal flag", 16'(illegal), 16'(exp_ill));
          chk(seen_n == exp_n, cur_tag, "memory read count", 16'(seen_n), 16'(exp_n));
          chk(wb_seen == int'(exp_wb), cur_tag, "writeback count", 16'(wb_seen), 16'(exp_wb));
          inflight = 0;
        end
        acc_pend = req_valid && !busy;
      end
    end
  end

  task automatic issue(input string tag, input logic [3:0] m, input logic [2:0] b,
                       input logic [2:0] x, input logic [15:0] disp,
                       input logic [15:0] step, input logic [15:0] pc, input bit hold);
    logic [15:0] bv, xv;
    bv = rf[b];
    xv = rf[x];
    cur_tag = tag;
    exp_n = 0; seen_n = 0; exp_wb = 0; wb_seen = 0; exp_ill = 0;
    exp_wsel = b; exp_wdata = '0;
    case (m)
      4'd0: exp_op = bv;
      4'd1: exp_op = disp;
      4'd2: begin exp_addr[0] = disp; exp_n = 1; end
      4'd3: begin exp_addr[0] = bv; exp_n = 1; end
      4'd4: begin exp_addr[0] = disp + bv; exp_n = 1; end
      4'd5: begin exp_addr[0] = bv + xv; exp_n = 1; end
      4'd6: begin exp_addr[0] = bv; exp_addr[1] = mf(bv); exp_n = 2; end
      4'd7: begin exp_addr[0] = bv; exp_n = 1; exp_wb = 1; exp_wdata = bv + step; end
      4'd8: begin exp_addr[0] = bv - step; exp_n = 1; exp_wb = 1; exp_wdata = bv - step; end
      4'd9: begin exp_addr[0] = disp + bv + 16'(xv * step); exp_n = 1; end
      4'd10: begin exp_addr[0] = pc + disp; exp_n = 1; end
      default: begin exp_op = '0; exp_ill = 1; end
    endcase
    if (exp_n > 0) exp_op = mf(exp_addr[exp_n-1]);
    req_mode = m; req_base = b; req_index = x;
    req_disp = disp; req_step = step; req_pc = pc;
    req_valid = 1;
    @(posedge clk); #1;
    if (hold) begin
      // R9: changed fields while busy must be ignored
      req_mode = 4'd1; req_disp = 16'hDEAD; req_base = 3'd7;
      repeat (2) begin @(posedge clk); #1; end
    end
    req_valid = 0;
    do @(negedge clk); while (!done);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !mem_req_valid && !rf_we, "R11", "reset outputs",
        {12'h0, busy, done, mem_req_valid, rf_we}, 16'h0);
    @(posedge clk); #1;
    for (int pass = 0; pass < 2; pass++) begin
      slow = (pass == 1);
      issue("R1",  4'd0, 3'd3, 3'd0, 16'h0000, 16'h0000, 16'h0000, 0);
      issue("R2",  4'd1, 3'd2, 3'd1, 16'hBEEF, 16'h0000, 16'h0000, 0);
      issue("R3",  4'd2, 3'd0, 3'd0, 16'h0420, 16'h0000, 16'h0000, 0);
      issue("R3",  4'd3, 3'd5, 3'd0, 16'h0000, 16'h0000, 16'h0000, 0);
      issue("R3",  4'd4, 3'd1, 3'd0, 16'hFFF0, 16'h0000, 16'h0000, 0);
      issue("R3",  4'd5, 3'd2, 3'd6, 16'h0000, 16'h0000, 16'h0000, 0);
      issue("R3",  4'd10, 3'd0, 3'd0, 16'h0010, 16'h0000, 16'h8000, 0);
      issue("R4",  4'd9, 3'd1, 3'd4, 16'h0100, 16'h0004, 16'h0000, 0);
      issue("R4",  4'd9, 3'd2, 3'd7, 16'h0003, 16'h0013, 16'h0000, 0);
      issue("R5",  4'd6, 3'd4, 3'd0, 16'h0000, 16'h0000, 16'h0000, 0);
      issue("R6",  4'd7, 3'd3, 3'd0, 16'h0000, 16'h0002, 16'h0000, 0);
      issue("R6",  4'd7, 3'd3, 3'd0, 16'h0000, 16'h0002, 16'h0000, 0);
      issue("R7",  4'd8, 3'd6, 3'd0, 16'h0000, 16'h0004, 16'h0000, 0);
      issue("R7",  4'd8, 3'd0, 3'd0, 16'h0000, 16'h2000, 16'h0000, 0);
      issue("R1",  4'd0, 3'd3, 3'd0, 16'h0000, 16'h0000, 16'h0000, 0);
      issue("R8",  4'd11, 3'd1, 3'd2, 16'h1234, 16'h0001, 16'h0000, 0);
      issue("R8",  4'd15, 3'd1, 3'd2, 16'h1234, 16'h0001, 16'h0000, 0);
      issue("R10", 4'd5, 3'd7, 3'd7, 16'h0000, 16'h0000, 16'h0000, 0);
    end
    slow = 1;
    issue("R9", 4'd6, 3'd5, 3'd0, 16'h0000, 16'h0000, 16'h0000, 1);
    slow = 0;
    issue("R9", 4'd3, 3'd7, 3'd0, 16'h0000, 16'h0000, 16'h0000, 1);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule